// File: doc/BRIEF.md
# Wrapping Line Burst Sequencer

This block breaks one request for a 32-byte line into a series of beats as wide as the bus. The first beat goes to the requested location, aligned down to the bus width, so the critical word comes first. Each later beat steps forward by the bus width and wraps at the edge of the 32-byte aligned line. The beat count follows from the width, so the whole line moves in every burst.

A single `start_i` pulse loads the address and width. The block then raises one beat-request strobe for each beat. It waits for the cycle timer's completion handshake before it issues the next strobe. The bus-lock output stays high for the whole burst, so no other master can take the bus between beats. A one-cycle done pulse closes the burst and releases the lock.

Top module: `wrap_burst_seq`

## Requirements
- R1: After reset, `beat_req_o`, `bus_lock_o` and `burst_done_o` are low.
- R2: When `start_i` is sampled high while the block is idle, `beat_req_o` and `bus_lock_o` are high in the next cycle. `beat_addr_o` then equals the start address with its low bits cleared to the bus width: bit 0 cleared for 16 bits, bits 1:0 cleared for 32 bits.
- R3: The width code on `width_i` selects the beat size: 0 means 8 bits, 1 means 16 bits, 2 means 32 bits, and 3 acts as 32 bits. A burst has 32, 16 or 8 beats for 8, 16 or 32 bits.
- R4: The low five address bits of each later beat equal those of the previous beat plus the beat size in bytes, modulo 32. Address bits above bit 4 keep the start address value for the whole burst.
- R5: `beat_req_o` is high for one cycle per beat. The next strobe comes in the cycle after `beat_done_i` is sampled high while a beat is outstanding, and never earlier.
- R6: `beat_done_i` is ignored in the cycle the strobe is high and while the block is idle.
- R7: `bus_lock_o` stays high from the first strobe through the cycle in which the last beat's `beat_done_i` is sampled. `burst_done_o` is then high for exactly one cycle, with `bus_lock_o` low in that cycle.
- R8: A `start_i` pulse, and any change on `start_addr_i` or `width_i`, during a burst or during its done cycle has no effect on that burst.
- R9: A new start is accepted in the cycle right after the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Burst start pulse |
| start_addr_i | input | ADDR_W | Requested byte address |
| width_i | input | 2 | Bus width code |
| beat_done_i | input | 1 | Completion handshake for the current beat |
| beat_req_o | output | 1 | One-cycle request strobe for a beat |
| beat_addr_o | output | ADDR_W | Address of the current beat |
| bus_lock_o | output | 1 | Bus held for the burst |
| burst_done_o | output | 1 | One-cycle end-of-burst pulse |

## Verification
Each kind of internal fault shows up at the ports in a different way:
- A corrupt offset or step register gives a wrong `beat_addr_o` at the very next strobe. The scoreboard compares every beat, so this is caught there.
- A beat counter that is off by one ends the burst early or late. This appears as a missing strobe or a misplaced `burst_done_o` within one handshake of the expected end.
- A state machine that accepts early or stray handshakes issues a strobe one cycle too soon.
- A state machine that reacts to `start_i` mid-burst changes the address of the next beat.

// File: rtl/wrap_burst_pkg.sv
package wrap_burst_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} burst_st_e;

  // width code to log2 of beat bytes; code 3 folds onto 32-bit
  function automatic logic [1:0] width_log2(logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/wrap_burst_addr.sv
module wrap_burst_addr #(
  parameter int ADDR_W  = 32,
  parameter int LINE_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        wlog_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UP_W = ADDR_W - LINE_AW;

  logic [UP_W-1:0]    upper_q;
  logic [LINE_AW-1:0] off_q;
  logic [1:0]         wlog_q;
  logic [LINE_AW-1:0] align_mask;
  logic [LINE_AW-1:0] step;

  for (genvar i = 0; i < LINE_AW; i++) begin : g_mask
    assign align_mask[i] = (i >= int'(wlog_i));
  end

  assign step = {{(LINE_AW-1){1'b0}}, 1'b1} << wlog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q <= '0;
      off_q   <= '0;
      wlog_q  <= '0;
    end else if (load_i) begin
      upper_q <= addr_i[ADDR_W-1:LINE_AW];
      off_q   <= addr_i[LINE_AW-1:0] & align_mask;
      wlog_q  <= wlog_i;
    end else if (adv_i) begin
      off_q   <= off_q + step;  // natural wrap inside the line
    end
  end

  assign addr_o = {upper_q, off_q};
endmodule

// File: rtl/wrap_burst_cnt.sv
module wrap_burst_cnt #(
  parameter int LINE_BYTES = 32,
  parameter int CNT_W      = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       dec_i,
  input  logic [1:0] wlog_i,
  output logic       last_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LINE_BYTES);

  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rem_q <= '0;
    else if (load_i)  rem_q <= FULL >> wlog_i;
    else if (dec_i)   rem_q <= rem_q - 1'b1;
  end

  assign last_o = (rem_q == CNT_W'(1));
endmodule

// File: rtl/wrap_burst_ctrl.sv
module wrap_burst_ctrl
  import wrap_burst_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  input  logic last_i,
  output logic load_o,
  output logic adv_o,
  output logic req_o,
  output logic lock_o,
  output logic fin_o
);
  burst_st_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    load_o = 1'b0;
    adv_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        load_o = 1'b1;
        st_d   = ST_REQ;
      end
      ST_REQ:  st_d = ST_WAIT;
      ST_WAIT: if (done_i) begin
        if (last_i) st_d = ST_DONE;
        else begin
          adv_o = 1'b1;
          st_d  = ST_REQ;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign req_o  = (st_q == ST_REQ);
  assign lock_o = (st_q == ST_REQ) || (st_q == ST_WAIT);
  assign fin_o  = (st_q == ST_DONE);
endmodule

// File: rtl/wrap_burst_seq.sv
module wrap_burst_seq
  import wrap_burst_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [1:0]        width_i,
  input  logic              beat_done_i,
  output logic              beat_req_o,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic              bus_lock_o,
  output logic              burst_done_o
);
  localparam int LINE_AW = $clog2(LINE_BYTES);
  localparam int CNT_W   = LINE_AW + 1;

  logic       load, adv, last;
  logic [1:0] wlog;

  assign wlog = width_log2(width_i);

  wrap_burst_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .done_i (beat_done_i),
    .last_i (last),
    .load_o (load),
    .adv_o  (adv),
    .req_o  (beat_req_o),
    .lock_o (bus_lock_o),
    .fin_o  (burst_done_o)
  );

  wrap_burst_addr #(.ADDR_W(ADDR_W), .LINE_AW(LINE_AW)) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .adv_i (adv),
    .addr_i(start_addr_i),
    .wlog_i(wlog),
    .addr_o(beat_addr_o)
  );

  wrap_burst_cnt #(.LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .dec_i (adv),
    .wlog_i(wlog),
    .last_o(last)
  );
endmodule

// File: rtl/wrap_burst_seq_chk.sv
module wrap_burst_seq_chk #(
  parameter int ADDR_W  = 32,
  parameter int LINE_AW = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              beat_done_i,
  input logic              beat_req_o,
  input logic [ADDR_W-1:0] beat_addr_o,
  input logic              bus_lock_o,
  input logic              burst_done_o
);
  // R7
  req_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_req_o |-> bus_lock_o);

  // R7
  done_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_done_o |-> (!bus_lock_o && !beat_req_o));

  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_done_o |=> !burst_done_o);

  // R5
  req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_req_o |=> !beat_req_o);

  // R5
  req_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_req_o && $past(bus_lock_o)) |-> $past(beat_done_i));

  // R2
  lock_with_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_lock_o) |-> beat_req_o);

  // R4
  upper_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_lock_o && $past(bus_lock_o)) |-> $stable(beat_addr_o[ADDR_W-1:LINE_AW]));
endmodule

bind wrap_burst_seq wrap_burst_seq_chk #(.ADDR_W(ADDR_W), .LINE_AW(LINE_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .beat_done_i (beat_done_i),
  .beat_req_o  (beat_req_o),
  .beat_addr_o (beat_addr_o),
  .bus_lock_o  (bus_lock_o),
  .burst_done_o(burst_done_o)
);

// File: tb/wrap_burst_seq_tb.sv
module wrap_burst_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic [1:0]  width_i = '0;
  logic        beat_done_i = 1'b0;
  logic        beat_req_o, bus_lock_o, burst_done_o;
  logic [31:0] beat_addr_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wrap_burst_seq u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_addr_i(start_addr_i),
    .width_i     (width_i),
    .beat_done_i (beat_done_i),
    .beat_req_o  (beat_req_o),
    .beat_addr_o (beat_addr_o),
    .bus_lock_o  (bus_lock_o),
    .burst_done_o(burst_done_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: every strobe pops one expected address (R4, R2)
  always @(negedge clk_i) begin
    if (rst_ni && beat_req_o) begin
      if (exp_q.size() == 0) chk("R4 unexpected beat", beat_addr_o, 32'hxxxx_xxxx);
      else chk("R4 beat address", beat_addr_o, exp_q.pop_front());
    end
  end

  // driver: enter and leave on a falling edge with the block idle
  task automatic run_burst(input logic [31:0] a, input logic [1:0] w,
                           input int lat, input bit poke);
    int wl    = (w == 2'd3) ? 2 : int'(w);
    int step  = 1 << wl;
    int beats = 32 >> wl;
    logic [4:0] off = a[4:0] & ~5'(step - 1);
    for (int b = 0; b < beats; b++) begin
      exp_q.push_back({a[31:5], off});
      off = off + 5'(step);
    end
    chk("R9 idle before start", {30'd0, bus_lock_o, burst_done_o}, 32'd0);
    start_addr_i = a; width_i = w; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int b = 0; b < beats; b++) begin
      chk("R5 strobe with lock", {30'd0, beat_req_o, bus_lock_o}, 32'd3);
      chk("R3 no early done", {31'd0, burst_done_o}, 32'd0);
      if (poke) beat_done_i = 1'b1;  // R6 handshake during strobe cycle
      @(negedge clk_i);
      beat_done_i = 1'b0;
      if (poke) begin  // R8 stray start and new inputs mid-burst
        start_i = 1'b1; start_addr_i = ~a; width_i = ~w;
      end
      for (int k = 0; k < lat; k++) begin
        chk("R5 wait holds", {30'd0, beat_req_o, bus_lock_o}, 32'd1);
        @(negedge clk_i);
      end
      start_i = 1'b0;
      chk("R6 no strobe before ack", {31'd0, beat_req_o}, 32'd0);
      beat_done_i = 1'b1;
      @(negedge clk_i);
      beat_done_i = 1'b0;
    end
    chk("R7 done pulse", {29'd0, burst_done_o, bus_lock_o, beat_req_o}, 32'd4);
    if (poke) start_i = 1'b1;  // R8 start during done cycle
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R7 done single", {29'd0, burst_done_o, bus_lock_o, beat_req_o}, 32'd0);
    chk("R3 beat count", exp_q.size(), 32'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset outputs", {29'd0, beat_req_o, bus_lock_o, burst_done_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    beat_done_i = 1'b1;  // R6 handshake while idle
    @(negedge clk_i);
    beat_done_i = 1'b0;
    chk("R6 idle ack ignored", {29'd0, beat_req_o, bus_lock_o, burst_done_o}, 32'd0);
    run_burst(32'h1000_0013, 2'd0, 0, 1'b0);   // R3 8-bit, 32 beats
    run_burst(32'h2000_0017, 2'd1, 2, 1'b1);   // R2 16-bit align
    run_burst(32'hABCD_EF3F, 2'd2, 1, 1'b1);   // R4 32-bit wrap
    run_burst(32'h0000_0005, 2'd3, 0, 1'b0);   // R3 code 3, R9 back-to-back
    run_burst(32'hFFFF_FFE0, 2'd2, 3, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule